// File: doc/BRIEF.md
# Complex Radix-2 Butterfly with Trivial-Twiddle Bypass

This block is the arithmetic core of one FFT stage. Each clock it can accept a pair of complex signed fixed-point samples, X0 and X1, and a complex twiddle W, and return the pair Y0 = X0 + W·X1 and Y1 = X0 − W·X1. The product P = W·X1 is formed once and is used by both the sum and the difference.

A three-bit twiddle-class input tells the block when W is one of the cheap values: +1, −1, +j, −j, +½ or −½. For these values the four-multiplier complex product is skipped. The product is then built by copying, negating, swapping the real and imaginary parts, or shifting right by one. The general path and every bypass path take the same three cycles, so results leave in the order they arrived. A valid flag travels with the data.

Every output is one bit wider than the data inputs, which absorbs the growth of one stage. Twiddle generation, stage sequencing, reordering and storage are the job of the surrounding datapath.

Top module: `bfly_r2`

## Requirements
- R1: On each valid result, y0 = x0 + P and y1 = x0 − P, lane by lane (real and imaginary), with the sum and difference taken modulo 2^(DW+1) at DW+1 bits. Both outputs use the same P.
- R2: When w_class is 0 (general), P_re = floor((w_re·x1_re − w_im·x1_im + 2^(FW−1)) / 2^FW) and P_im = floor((w_re·x1_im + w_im·x1_re + 2^(FW−1)) / 2^FW). The twiddle uses the same format as the data (DW bits, FW fraction bits), and ties round upward.
- R3: When w_class is 1 (W = +1), P = X1 exactly.
- R4: When w_class is 2 (W = −1), P = −X1 exactly, computed at DW+1 bits so that −(−2^(DW−1)) is representable.
- R5: When w_class is 3 (W = −j), P = (x1_im, −x1_re). When w_class is 4 (W = +j), P = (−x1_im, x1_re).
- R6: When w_class is 5 (W = +½), P = x1 >>> 1, an arithmetic shift that rounds toward minus infinity. When w_class is 6 (W = −½), P = (−x1) >>> 1.
- R7: For classes 1 to 6, w_re and w_im have no effect on the outputs. Class 7 is handled exactly like class 0.
- R8: A sample taken with in_valid high at clock edge k appears with out_valid high after edge k+3, whatever its class. Samples on consecutive cycles produce results on consecutive cycles, in input order.
- R9: A synchronous active-high rst clears every valid stage. out_valid is low on the first cycle after a reset edge and stays low until a new sample has had three cycles to pass through.
- R10: The outputs are DW+1 bits wide. Full-scale negative inputs (−2^(DW−1)) on every trivial class give exact results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample pair is valid |
| w_class | input | 3 | Twiddle class: 0 general, 1 +1, 2 −1, 3 −j, 4 +j, 5 +½, 6 −½, 7 general |
| x0_re | input | DW | X0 real part, signed |
| x0_im | input | DW | X0 imaginary part, signed |
| x1_re | input | DW | X1 real part, signed |
| x1_im | input | DW | X1 imaginary part, signed |
| w_re | input | DW | Twiddle real part, signed, FW fraction bits |
| w_im | input | DW | Twiddle imaginary part, signed, FW fraction bits |
| out_valid | output | 1 | Result pair is valid |
| y0_re | output | DW+1 | Y0 real part, signed |
| y0_im | output | DW+1 | Y0 imaginary part, signed |
| y1_re | output | DW+1 | Y1 real part, signed |
| y1_im | output | DW+1 | Y1 imaginary part, signed |

## Verification
The general path is tried with a unit twiddle, a twiddle of about 45°, a −j written as a general value on full-scale negative data, and half-way products of both signs. These separate a wrong sign in a cross term, a swapped product pair, and rounding down in place of rounding up. Each bypass class is given full-scale negative or odd negative data, together with nonzero garbage on the twiddle inputs. This exposes a negation done at input width, a shift placed before the negation, swapped ±j cases, and a twiddle that leaks into a bypass path. A back-to-back stream that mixes all classes, a single isolated sample and a reset in mid-flight tell apart latency mismatches between the paths, reordering, and valid flags that survive reset.

// File: rtl/bfly_r2_pkg.sv
package bfly_r2_pkg;
  typedef enum logic [2:0] {
    TW_GENERAL = 3'd0,
    TW_POS_ONE = 3'd1,
    TW_NEG_ONE = 3'd2,
    TW_NEG_J   = 3'd3,
    TW_POS_J   = 3'd4,
    TW_POS_HALF = 3'd5,
    TW_NEG_HALF = 3'd6,
    TW_GENERAL_ALT = 3'd7
  } tw_class_e;

  localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/bfly_mul.sv
module bfly_mul
  import bfly_r2_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic [2:0]           cls,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic signed [DW:0]   p_re,
  output logic signed [DW:0]   p_im
);
  localparam int PW = DW + 1;
  localparam int MW = 2 * DW;
  localparam int SW = MW + 2;
  localparam logic signed [SW-1:0] RND = SW'(1) << (FW - 1);

  // bypass product for a trivial twiddle, packed {re, im}
  function automatic logic signed [2*PW-1:0] trivial_prod(
    input logic [2:0] c, input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
    logic signed [PW-1:0] ea, eb, ra, rb;
    ea = PW'(a);
    eb = PW'(b);
    case (tw_class_e'(c))
      TW_NEG_ONE:  begin ra = -ea;        rb = -eb;        end
      TW_NEG_J:    begin ra = eb;         rb = -ea;        end
      TW_POS_J:    begin ra = -eb;        rb = ea;         end
      TW_POS_HALF: begin ra = ea >>> 1;   rb = eb >>> 1;   end
      TW_NEG_HALF: begin ra = (-ea) >>> 1; rb = (-eb) >>> 1; end
      default:     begin ra = ea;         rb = eb;         end
    endcase
    return {ra, rb};
  endfunction

  // round-half-up back to FW fraction bits, keep PW bits
  function automatic logic signed [PW-1:0] round_fx(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] t;
    t = (s + RND) >>> FW;
    return t[PW-1:0];
  endfunction

  logic signed [DW-1:0] opa [4];
  logic signed [DW-1:0] opb [4];
  logic signed [MW-1:0] prod_q [4];
  logic signed [2*PW-1:0] triv_q;
  logic                   gen_q;

  // order: re*re, im*im, re*w_im, im*w_re
  assign opa[0] = x_re; assign opb[0] = w_re;
  assign opa[1] = x_im; assign opb[1] = w_im;
  assign opa[2] = x_re; assign opb[2] = w_im;
  assign opa[3] = x_im; assign opb[3] = w_re;

  for (genvar g = 0; g < 4; g++) begin : g_mult
    always_ff @(posedge clk) prod_q[g] <= MW'(opa[g]) * MW'(opb[g]);
  end

  always_ff @(posedge clk) begin
    triv_q <= trivial_prod(cls, x_re, x_im);
    gen_q  <= (cls == TW_GENERAL) || (cls == TW_GENERAL_ALT);
  end

  logic signed [SW-1:0] sum_re, sum_im;
  assign sum_re = SW'(prod_q[0]) - SW'(prod_q[1]);
  assign sum_im = SW'(prod_q[2]) + SW'(prod_q[3]);

  always_ff @(posedge clk) begin
    p_re <= gen_q ? round_fx(sum_re) : triv_q[2*PW-1:PW];
    p_im <= gen_q ? round_fx(sum_im) : triv_q[PW-1:0];
  end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW:0]   p,
  output logic signed [DW:0]   y0,
  output logic signed [DW:0]   y1
);
  localparam int PW = DW + 1;

  logic signed [PW-1:0] ext;
  assign ext = PW'(x0);

  always_ff @(posedge clk) begin
    y0 <= ext + p;
    y1 <= ext - p;
  end
endmodule

// File: rtl/bfly_r2.sv
module bfly_r2
  import bfly_r2_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           w_class,
  input  logic signed [DW-1:0] x0_re,
  input  logic signed [DW-1:0] x0_im,
  input  logic signed [DW-1:0] x1_re,
  input  logic signed [DW-1:0] x1_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic                 out_valid,
  output logic signed [DW:0]   y0_re,
  output logic signed [DW:0]   y0_im,
  output logic signed [DW:0]   y1_re,
  output logic signed [DW:0]   y1_im
);
  localparam int PW = DW + 1;
  localparam int ND = PIPE_DEPTH;

  logic [ND-1:0] vld_q;
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[ND-2:0], in_valid};
  end
  assign out_valid = vld_q[ND-1];

  // named internal events for the checker
  logic              prod_valid;
  logic signed [PW-1:0] prod_re, prod_im;
  assign prod_valid = vld_q[1];

  bfly_mul #(.DW(DW), .FW(FW)) mul_i (
    .clk(clk), .cls(w_class),
    .x_re(x1_re), .x_im(x1_im), .w_re(w_re), .w_im(w_im),
    .p_re(prod_re), .p_im(prod_im)
  );

  logic signed [DW-1:0] x0_d1 [2];
  logic signed [DW-1:0] x0_d2 [2];
  always_ff @(posedge clk) begin
    x0_d1[0] <= x0_re;
    x0_d1[1] <= x0_im;
    x0_d2    <= x0_d1;
  end

  logic signed [PW-1:0] p_lane  [2];
  logic signed [PW-1:0] y0_lane [2];
  logic signed [PW-1:0] y1_lane [2];
  assign p_lane[0] = prod_re;
  assign p_lane[1] = prod_im;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    bfly_addsub #(.DW(DW)) as_i (
      .clk(clk), .x0(x0_d2[l]), .p(p_lane[l]),
      .y0(y0_lane[l]), .y1(y1_lane[l])
    );
  end

  assign y0_re = y0_lane[0];
  assign y0_im = y0_lane[1];
  assign y1_re = y1_lane[0];
  assign y1_im = y1_lane[1];
endmodule

// File: rtl/bfly_r2_chk.sv
module bfly_r2_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [2:0]           w_class,
  input logic signed [DW-1:0] x0_re,
  input logic signed [DW-1:0] x1_re,
  input logic                 prod_valid,
  input logic signed [DW:0]   prod_re,
  input logic                 out_valid,
  input logic signed [DW:0]   y0_re,
  input logic signed [DW:0]   y1_re
);
  localparam int PW = DW + 1;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic signed [PW-1:0] ysum, ydiff;
  assign ysum  = y0_re + y1_re;
  assign ydiff = y0_re - y1_re;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R9

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R8

  AST_SHARED_SUM: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_valid) |-> (ysum == {$past(x0_re, 3), 1'b0})); // R1

  AST_UNIT_DIFF: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_valid && $past(w_class, 3) == 3'd1)
      |-> (ydiff == {$past(x1_re, 3), 1'b0})); // R3

  AST_NEG_UNIT_PROD: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && prod_valid && $past(w_class, 2) == 3'd2)
      |-> (prod_re == -PW'($past(x1_re, 2)))); // R4
endmodule

bind bfly_r2 bfly_r2_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .w_class(w_class),
  .x0_re(x0_re), .x1_re(x1_re), .prod_valid(prod_valid), .prod_re(prod_re),
  .out_valid(out_valid), .y0_re(y0_re), .y1_re(y1_re)
);

// File: tb/bfly_r2_tb_top.sv
`timescale 1ns/1ps
module bfly_r2_tb_top;
  localparam int DW = 16;
  localparam int FW = 8;
  localparam int NV = 13;
  localparam int VW = 3 + 6 * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] w_class = '0;
  logic signed [DW-1:0] x0_re = '0, x0_im = '0, x1_re = '0, x1_im = '0, w_re = '0, w_im = '0;
  logic out_valid;
  logic signed [DW:0] y0_re, y0_im, y1_re, y1_im;

  always #10 clk = ~clk;

  bfly_r2 #(.DW(DW), .FW(FW)) dut_i (.*);

  int checks = 0;
  int fails = 0;

  // {class, x0_re, x0_im, x1_re, x1_im, w_re, w_im}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 16'sd100, -16'sd50, 16'sd256, 16'sd128, 16'sd256, 16'sd0},        // R2 unit as general
    {3'd0, 16'sd7, 16'sd9, 16'sd1000, -16'sd700, 16'sd181, -16'sd181},       // R2 45 deg
    {3'd0, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'sd0, -16'sd256},       // R2 R10 full scale
    {3'd1, 16'sd5, -16'sd3, 16'h8000, 16'sd32767, 16'sd1234, -16'sd999},     // R3 R7 garbage w
    {3'd2, 16'h8000, 16'h8000, 16'h8000, 16'h8000, -16'sd77, 16'sd55},       // R4 R10
    {3'd3, 16'sd10, 16'sd20, 16'sd300, -16'sd40, 16'sd99, 16'sd99},          // R5 -j
    {3'd4, 16'sd10, 16'sd20, 16'sd300, -16'sd40, 16'sd99, 16'sd99},          // R5 +j
    {3'd5, 16'sd0, 16'sd1, -16'sd3, 16'sd5, 16'sd500, 16'sd500},             // R6 +half odd
    {3'd6, 16'sd2, 16'sd0, 16'h8000, -16'sd3, -16'sd500, 16'sd1},            // R6 -half
    {3'd7, 16'sd1, 16'sd2, 16'sd1000, -16'sd700, 16'sd181, -16'sd181},       // R7 class 7 general
    {3'd0, 16'sd0, 16'sd0, 16'sd1, -16'sd1, 16'sd128, 16'sd0},               // R2 ties
    {3'd0, 16'sd3, 16'sd4, 16'h8000, 16'sd5, -16'sd256, 16'sd0},             // R2 negate via W
    {3'd3, 16'h8000, 16'sd0, 16'h8000, 16'h8000, 16'sd0, 16'sd0}             // R5 R10 full scale
  };

  function automatic logic signed [DW:0] wrap(input longint v);
    return v[DW:0];
  endfunction

  function automatic longint fl_div(input longint n);
    longint q;
    q = n / 256;
    if (n < 0 && q * 256 != n) q = q - 1;
    return q;
  endfunction

  // independent model: returns {y0_re, y0_im, y1_re, y1_im}
  function automatic logic [4*(DW+1)-1:0] model(input logic [VW-1:0] v);
    longint a0, b0, a1, b1, wr, wi, pr, pi;
    int c;
    c  = int'(v[VW-1 -: 3]);
    a0 = longint'($signed(v[6*DW-1 -: DW]));
    b0 = longint'($signed(v[5*DW-1 -: DW]));
    a1 = longint'($signed(v[4*DW-1 -: DW]));
    b1 = longint'($signed(v[3*DW-1 -: DW]));
    wr = longint'($signed(v[2*DW-1 -: DW]));
    wi = longint'($signed(v[DW-1 -: DW]));
    case (c)
      1: begin pr = a1;  pi = b1;  end
      2: begin pr = -a1; pi = -b1; end
      3: begin pr = b1;  pi = -a1; end
      4: begin pr = -b1; pi = a1;  end
      5: begin pr = fl_div(a1 * 128); pi = fl_div(b1 * 128); end
      6: begin pr = fl_div(-a1 * 128); pi = fl_div(-b1 * 128); end
      default: begin
        pr = fl_div(wr * a1 - wi * b1 + 128);
        pi = fl_div(wr * b1 + wi * a1 + 128);
      end
    endcase
    return {wrap(a0 + pr), wrap(b0 + pi), wrap(a0 - pr), wrap(b0 - pi)};
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      3'd7: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check_bit(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s out_valid actual %0b expected %0b", rq, act, exp);
    end
  endtask

  task automatic check_vec(input int i);
    logic [4*(DW+1)-1:0] e, a;
    checks++;
    e = model(VEC[i]);
    a = {y0_re, y0_im, y1_re, y1_im};
    if (a !== e) begin
      fails++;
      $display("FAIL %s/R1 vector %0d actual %h expected %h", req_of(VEC[i][VW-1 -: 3]), i, a, e);
    end
  endtask

  task automatic drive(input int i, input logic v);
    in_valid = v;
    {w_class, x0_re, x0_im, x1_re, x1_im, w_re, w_im} = VEC[i];
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int got;
    int first_out;
    repeat (3) @(negedge clk);
    check_bit("R9 reset", out_valid, 1'b0);
    rst = 1'b0;

    // back-to-back stream of the table, R8 order and latency
    got = 0;
    first_out = -1;
    for (int cyc = 0; cyc < NV + 6; cyc++) begin
      @(negedge clk);
      if (out_valid) begin
        if (first_out < 0) first_out = cyc;
        if (got < NV) check_vec(got);
        got++;
      end
      if (cyc < NV) drive(cyc, 1'b1);
      else in_valid = 1'b0;
    end
    checks++;
    if (got != NV || first_out != 3) begin
      fails++;
      $display("FAIL R8 stream count actual %0d/%0d expected %0d/3", got, first_out, NV);
    end

    // isolated sample: R8 latency exactly three edges
    @(negedge clk);
    drive(8, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R8 edge1", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R8 edge2", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R8 edge3", out_valid, 1'b1);
    check_vec(8);
    @(negedge clk);
    check_bit("R8 single", out_valid, 1'b0);

    // R7: same X with other twiddle garbage on a bypass class
    drive(3, 1'b1);
    w_re = 16'sd7;
    w_im = 16'sd300;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_bit("R7 valid", out_valid, 1'b1);
    check_vec(3);

    // R9: reset in mid-flight kills queued samples
    @(negedge clk);
    drive(0, 1'b1);
    @(negedge clk);
    drive(1, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_bit("R9 after reset", out_valid, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_bit("R9 flushed", out_valid, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule